// File: doc/BRIEF.md
# Host-Side Read Prefetch FIFO

This block holds a small number of 32-bit words fetched from the PCI side while the processor reads from PCI, and hands them to the 64-bit host data bus one at a time. Load strobes from the PCI side write incoming words into successive entries. At the same time, the block computes a parity bit for each word and stores it with that entry.

On the host side, read commands step through the entries strictly in order. There is no random access. Each read command picks one of three pointer actions:

- keep the current entry, so that reads narrower than a word can reuse it;
- advance to the next entry before driving it;
- rewind to the first entry.

The selected word is copied onto both 32-bit halves of the host bus, and its stored parity bit appears on a separate output. No per-byte parity is produced on the host output.

A clear input empties the buffer between transfers. Two sticky flags report misuse:

- an overflow flag, raised by a load into a full buffer;
- an underflow flag, raised by an advance past the last valid entry.

Top module: `host_rd_prefetch`

## Requirements
- R1: After synchronous reset, `host_data` is all zeros, `host_par` is 0, and both `ovf_flag` and `udf_flag` are 0.
- R2: Each `ld_vld` pulse writes `ld_data` into the next free entry, starting at entry 0 and filling entries in order. Up to DEPTH (default 4) words can be held.
- R3: A read command with `rd_inc`=0 and `rd_rewind`=0 drives the entry under the read pointer and leaves the pointer where it is, so repeated reads return the same word.
- R4: A read command with `rd_inc`=1 first advances the read pointer by one entry and then drives the new entry, so successive advances return the loaded words in load order.
- R5: A read command with `rd_rewind`=1 sets the read pointer to entry 0 and drives entry 0. Rewind takes priority over `rd_inc`.
- R6: `host_data[63:32]` always equals `host_data[31:0]`.
- R7: `host_par` is the even parity bit (the XOR of all 32 bits) of the word currently shown in `host_data[31:0]`.
- R8: `host_data` and `host_par` change only on the clock edge that takes a read command, become valid one clock after it, and hold their value while no read command arrives.
- R9: A load while DEPTH entries are already valid is ignored: stored contents do not change. It also sets `ovf_flag`, which stays 1 until clear or reset.
- R10: An advance (`rd_inc`=1) when the next entry is not valid leaves the read pointer unchanged and drives the current entry again. It also sets `udf_flag`, which stays 1 until clear or reset.
- R11: `buf_clr` returns the write pointer, read pointer and valid count to zero and clears both flags. `buf_clr` overrides a load or read in the same cycle, and the next load goes into entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_clr | input | 1 | Empties the buffer and clears the flags |
| ld_vld | input | 1 | PCI-side load strobe |
| ld_data | input | 32 | Word to load |
| rd_cmd | input | 1 | Host-side read command strobe |
| rd_inc | input | 1 | Advance the pointer before driving |
| rd_rewind | input | 1 | Rewind the pointer to entry 0 before driving |
| host_data | output | 64 | Selected word copied onto both halves |
| host_par | output | 1 | Even parity of the selected word |
| ovf_flag | output | 1 | Sticky: a load arrived while the buffer was full |
| udf_flag | output | 1 | Sticky: an advance went past the last valid entry |

## Verification
The assertions check on every cycle that:
- the two host halves match and the parity bit agrees with the displayed word;
- the outputs stay still when no read command arrives;
- the pointer holds on a plain read, returns to zero on a rewind, and holds with the underflow flag set on an overflowing advance;
- a load into a full buffer leaves the count unchanged and raises the overflow flag.

What the assertions cannot show is that the right word comes out. Only the bench scenarios show that:
- words come back in load order;
- a rewind returns the very first word;
- the word rejected on overflow never appears;
- after a clear, a new word lands in entry 0 in place of stale data.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

    localparam int WORD_W = 32;

    typedef struct packed {
        logic              par;
        logic [WORD_W-1:0] data;
    } entry_t;

    typedef enum logic [1:0] {
        PTR_STAY  = 2'd0,
        PTR_NEXT  = 2'd1,
        PTR_FIRST = 2'd2
    } ptr_act_e;

    typedef struct packed {
        logic     go;
        ptr_act_e act;
    } rd_req_t;

    function automatic rd_req_t decode_rd(input logic cmd, input logic inc, input logic rew);
        rd_req_t r;
        r.go  = cmd;
        if (rew)      r.act = PTR_FIRST;
        else if (inc) r.act = PTR_NEXT;
        else          r.act = PTR_STAY;
        return r;
    endfunction

    function automatic logic even_par(input logic [WORD_W-1:0] d);
        return ^d;
    endfunction

endpackage

// File: rtl/hrp_store.sv
module hrp_store
    import hrp_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              ld_vld,
    input  logic [WORD_W-1:0] ld_data,
    input  logic [PW-1:0]     sel_idx,
    output entry_t            sel_entry,
    output logic [CW-1:0]     cnt,
    output logic              ovf
);

    logic [PW-1:0] wp;
    logic          full;
    logic          ld_ok;
    entry_t        ents [DEPTH];

    assign full  = (cnt == CW'(DEPTH));
    assign ld_ok = ld_vld && !clr && !full;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ents[i] <= '0;
            end else if (ld_ok && wp == PW'(i)) begin
                ents[i].data <= ld_data;
                ents[i].par  <= even_par(ld_data);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp  <= '0;
            cnt <= '0;
            ovf <= 1'b0;
        end else if (ld_vld) begin
            if (full) begin
                ovf <= 1'b1;
            end else begin
                wp  <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign sel_entry = ents[sel_idx];

    // R2
    ld_count_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_vld && !clr && !full) |=> cnt == $past(cnt) + 1'b1);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_vld && !clr && full) |=> (ovf && $stable(cnt) && $stable(wp)));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr) |=> ovf);

    // R11
    clr_store_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0 && wp == '0 && !ovf));

endmodule

// File: rtl/hrp_rdctl.sv
module hrp_rdctl
    import hrp_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  rd_req_t       req,
    input  logic [CW-1:0] cnt,
    output logic [PW-1:0] rp_nxt,
    output logic          fire,
    output logic          udf
);

    logic [PW-1:0] rp;
    logic [CW-1:0] ahead;
    logic          past_end;

    assign fire     = req.go && !clr;
    assign ahead    = CW'(rp) + 1'b1;
    assign past_end = (ahead >= cnt);

    always_comb begin
        rp_nxt = rp;
        if (fire) begin
            unique case (req.act)
                PTR_FIRST: rp_nxt = '0;
                PTR_NEXT:  rp_nxt = past_end ? rp : rp + 1'b1;
                default:   rp_nxt = rp;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rp  <= '0;
            udf <= 1'b0;
        end else begin
            rp <= rp_nxt;
            if (fire && req.act == PTR_NEXT && past_end) udf <= 1'b1;
        end
    end

    // R3
    stay_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && req.act == PTR_STAY) |=> $stable(rp));

    // R5
    rewind_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && req.act == PTR_FIRST) |=> rp == '0);

    // R10
    underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && req.act == PTR_NEXT && past_end) |=> ($stable(rp) && udf));

    // R11
    clr_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (rp == '0 && !udf));

endmodule

// File: rtl/hrp_outreg.sv
module hrp_outreg
    import hrp_pkg::*;
#(
    parameter int LANES = 2,
    localparam int OW = LANES * WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  entry_t        sel_entry,
    output logic [OW-1:0] host_data,
    output logic          host_par
);

    logic [WORD_W-1:0] word_q;
    logic              par_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            par_q  <= 1'b0;
        end else if (fire) begin
            word_q <= sel_entry.data;
            par_q  <= sel_entry.par;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign host_data[l*WORD_W +: WORD_W] = word_q;
    end
    assign host_par = par_q;

    // R8
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        !fire |=> ($stable(host_data) && $stable(host_par)));

endmodule

// File: rtl/host_rd_prefetch.sv
module host_rd_prefetch
    import hrp_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LANES = 2,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int OW = LANES * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              buf_clr,
    input  logic              ld_vld,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              rd_cmd,
    input  logic              rd_inc,
    input  logic              rd_rewind,
    output logic [OW-1:0]     host_data,
    output logic              host_par,
    output logic              ovf_flag,
    output logic              udf_flag
);

    rd_req_t       req;
    logic [PW-1:0] rp_nxt;
    logic [CW-1:0] cnt;
    logic          fire;
    entry_t        sel_entry;

    assign req = decode_rd(rd_cmd, rd_inc, rd_rewind);

    hrp_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .clr       (buf_clr),
        .ld_vld    (ld_vld),
        .ld_data   (ld_data),
        .sel_idx   (rp_nxt),
        .sel_entry (sel_entry),
        .cnt       (cnt),
        .ovf       (ovf_flag)
    );

    hrp_rdctl #(.DEPTH(DEPTH)) u_rdctl (
        .clk    (clk),
        .rst    (rst),
        .clr    (buf_clr),
        .req    (req),
        .cnt    (cnt),
        .rp_nxt (rp_nxt),
        .fire   (fire),
        .udf    (udf_flag)
    );

    hrp_outreg #(.LANES(LANES)) u_out (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .sel_entry (sel_entry),
        .host_data (host_data),
        .host_par  (host_par)
    );

    // R6
    lanes_match_chk: assert property (@(posedge clk) disable iff (rst)
        host_data[OW-1 -: WORD_W] == host_data[WORD_W-1:0]);

    // R7
    parity_match_chk: assert property (@(posedge clk) disable iff (rst)
        host_par == even_par(host_data[WORD_W-1:0]));

endmodule

// File: tb/host_rd_prefetch_tb.sv
`timescale 1ns/1ps
module host_rd_prefetch_tb;

    logic        clk = 1'b0;
    logic        rst, buf_clr, ld_vld, rd_cmd, rd_inc, rd_rewind;
    logic [31:0] ld_data;
    logic [63:0] host_data;
    logic        host_par, ovf_flag, udf_flag;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    host_rd_prefetch u_dut (
        .clk(clk), .rst(rst), .buf_clr(buf_clr), .ld_vld(ld_vld), .ld_data(ld_data),
        .rd_cmd(rd_cmd), .rd_inc(rd_inc), .rd_rewind(rd_rewind),
        .host_data(host_data), .host_par(host_par),
        .ovf_flag(ovf_flag), .udf_flag(udf_flag)
    );

    // op: 0 load, 1 read stay, 2 read advance, 3 read rewind
    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] val;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{2'd0, 32'h0000_0001, 8'd2},
        '{2'd0, 32'hA5A5_5A5A, 8'd2},
        '{2'd0, 32'h8000_0003, 8'd2},
        '{2'd0, 32'hFFFF_FFFE, 8'd2},
        '{2'd1, 32'h0000_0001, 8'd3},
        '{2'd1, 32'h0000_0001, 8'd3},
        '{2'd2, 32'hA5A5_5A5A, 8'd4},
        '{2'd2, 32'h8000_0003, 8'd4},
        '{2'd3, 32'h0000_0001, 8'd5},
        '{2'd2, 32'hA5A5_5A5A, 8'd4},
        '{2'd2, 32'h8000_0003, 8'd4},
        '{2'd2, 32'hFFFF_FFFE, 8'd4}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic [31:0] w);
        check(host_data == {w, w}, req, host_data, {w, w});
        check(host_par == (^w), {req, " R7 parity"}, 64'(host_par), 64'(^w));
    endtask

    task automatic do_load(input logic [31:0] d);
        ld_vld = 1'b1; ld_data = d;
        tick();
        ld_vld = 1'b0;
    endtask

    task automatic do_read(input logic inc, input logic rew);
        rd_cmd = 1'b1; rd_inc = inc; rd_rewind = rew;
        tick();
        rd_cmd = 1'b0; rd_inc = 1'b0; rd_rewind = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; buf_clr = 1'b0; ld_vld = 1'b0; ld_data = '0;
        rd_cmd = 1'b0; rd_inc = 1'b0; rd_rewind = 1'b0;
        tick(); tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        check(host_data == 64'd0, "R1 data", host_data, 64'd0);
        check({host_par, ovf_flag, udf_flag} == 3'b000, "R1 par/flags",
              64'({host_par, ovf_flag, udf_flag}), 64'd0);

        // table walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < 12; i++) begin
            if (VECS[i].op == 2'd0) begin
                do_load(VECS[i].val);
            end else begin
                do_read(VECS[i].op == 2'd2, VECS[i].op == 2'd3);
                check_out($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].val);
            end
        end

        // R10 advance past last valid entry
        do_read(1'b1, 1'b0);
        check_out("R10 hold on underflow", 32'hFFFF_FFFE);
        check(udf_flag == 1'b1, "R10 udf set", 64'(udf_flag), 64'd1);
        tick();
        check(udf_flag == 1'b1, "R10 udf sticky", 64'(udf_flag), 64'd1);

        // R9 overflow: fifth load rejected
        do_load(32'h1357_9BDF);
        check(ovf_flag == 1'b1, "R9 ovf set", 64'(ovf_flag), 64'd1);

        // R8 output holds without a read command
        tick(); tick();
        check_out("R8 hold idle", 32'hFFFF_FFFE);

        // R5 rewind priority over advance; R8 one-cycle latency
        rd_cmd = 1'b1; rd_inc = 1'b1; rd_rewind = 1'b1;
        #1;
        check_out("R8 no change before edge", 32'hFFFF_FFFE);
        tick();
        rd_cmd = 1'b0; rd_inc = 1'b0; rd_rewind = 1'b0;
        check_out("R5 rewind wins", 32'h0000_0001);

        // R9 rejected word never stored: walk all four entries
        do_read(1'b1, 1'b0); do_read(1'b1, 1'b0); do_read(1'b1, 1'b0);
        check_out("R9 last entry intact", 32'hFFFF_FFFE);
        check(ovf_flag == 1'b1, "R9 ovf sticky", 64'(ovf_flag), 64'd1);

        // R11 clear, clear overrides a simultaneous load
        buf_clr = 1'b1; ld_vld = 1'b1; ld_data = 32'hDEAD_BEEF;
        tick();
        buf_clr = 1'b0; ld_vld = 1'b0;
        check({ovf_flag, udf_flag} == 2'b00, "R11 flags cleared",
              64'({ovf_flag, udf_flag}), 64'd0);
        do_load(32'h1234_5678);
        do_read(1'b0, 1'b0);
        check_out("R11 new load at entry 0", 32'h1234_5678);

        // R10 with a single valid entry
        do_read(1'b1, 1'b0);
        check_out("R10 single entry hold", 32'h1234_5678);
        check(udf_flag == 1'b1, "R10 udf single", 64'(udf_flag), 64'd1);
        check(ovf_flag == 1'b0, "R9 no ovf below full", 64'(ovf_flag), 64'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule